// File: doc/BRIEF.md
# Streaming Automatic Volume Control

The block sits in a digital audio path and sets its own gain. Each valid input sample is multiplied by a linear gain. That gain comes from a gain value held in dB, which moves by a small signed step on every valid sample. The block tracks a peak envelope of the gain-adjusted output. While the envelope is above a programmable threshold, the gain falls by the attack step. Otherwise it rises by the decay step until it reaches a selectable ceiling.

With the ceiling set to 0 dB the gain can never rise above unity, so the block only acts as a limiter on loud passages. When the enable input is low the samples pass straight through, and the gain and envelope return to their rest values.

Steps are given in units of 2^-20 dB per sample. At a 48 kHz sample rate, one unit is about 0.046 dB/s. So an attack of 0.05 dB/s is about 1 unit, and a decay of 3200 dB/s is about 69905 units. Both fit the 18-bit step ports.

Top module: `avc_core`

## Requirements
- R1: While reset is held and after it is released, out_valid is 0 and out_sample is 0, and the gain starts at 0 dB.
- R2: The gain ceiling is 0 dB for max_sel 0, 6 dB for max_sel 1, and 12 dB for max_sel 2 or 3. The gain never exceeds the ceiling.
- R3: With max_sel 0 and an envelope that never exceeds the threshold, every output sample equals its input sample.
- R4: On a valid enabled sample whose envelope is strictly above thresh, the gain drops by attack_step (units of 2^-20 dB) and never goes below -24 dB. Sample k uses the gain left by the update at sample k-1. The envelope compared at sample k includes outputs up to sample k-2.
- R5: On a valid enabled sample whose envelope is not above thresh, the gain rises by decay_step (units of 2^-20 dB) and stops at the ceiling.
- R6: The envelope is unsigned and starts at 0. For every output y it becomes max(|y|, env - (env >> 8)). After loud input stops, it therefore leaks away and the gain recovers to the ceiling.
- R7: The gain g maps to a linear factor in Q14 through a 73-entry table T, one entry per 0.5 dB from -24 dB. T[48] = 16384. Going up, T[k+1] = floor(T[k]*69419/65536). Going down, T[k-1] = floor(T[k]*61870/65536). With off = g + 24*2^20, i = off>>19 and f = bits 18..11 of off, the factor is T[i] + floor((T[i+1]-T[i])*f/256), with T[i+1] replaced by T[i] at the top entry.
- R8: The output is floor(x*lin/16384), saturated to the signed range of the sample width (32767 / -32768 for 16 bits).
- R9: A sample presented with in_valid at one clock edge appears with out_valid high after the next edge, giving two register stages.
- R10: While en is low the output equals the input exactly, and the gain and envelope are reset to 0 dB and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable; low gives bypass and state reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | DW | Signed input sample |
| thresh | input | DW | Unsigned level threshold |
| max_sel | input | 2 | Gain ceiling select |
| attack_step | input | RW | Gain decrement per sample above threshold |
| decay_step | input | RW | Gain increment per sample at or below threshold |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | DW | Signed gain-adjusted sample |

## Verification
The step-bound and ceiling assertions assume that the configuration inputs change only while en is low or between runs. They also assume that max_sel is driven with a defined 2-bit code. The stimulus follows this: each run first drops en to clear the state, then sets the configuration, and holds it for the whole stream. The envelope rule needs in_sample to stay within the signed range, which holds because the bench drives only real sample values, including both extremes.

// File: rtl/avc_core.sv
module avc_core #(
  parameter int DW     = 16,
  parameter int RW     = 18,
  parameter int FRAC   = 20,
  parameter int MIN_DB = 24,
  parameter int LEAK   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          in_valid,
  input  logic [DW-1:0] in_sample,
  input  logic [DW-1:0] thresh,
  input  logic [1:0]    max_sel,
  input  logic [RW-1:0] attack_step,
  input  logic [RW-1:0] decay_step,
  output logic          out_valid,
  output logic [DW-1:0] out_sample
);
  localparam int GW    = FRAC + 8;
  localparam int HALF  = FRAC - 1;
  localparam int ZI    = 2 * MIN_DB;
  localparam int NSTEP = 2 * (MIN_DB + 12);
  localparam int IW    = $clog2(NSTEP + 1);
  localparam int LW    = 18;
  localparam int PW    = DW + LW + 1;
  localparam longint UNITY = 64'd16384;
  localparam logic signed [GW-1:0] DB6  = GW'(6)  <<< FRAC;
  localparam logic signed [GW-1:0] DB12 = GW'(12) <<< FRAC;
  localparam logic signed [GW-1:0] GMIN = -(GW'(MIN_DB) <<< FRAC);

  function automatic logic [NSTEP:0][LW-1:0] build_lut();
    logic [NSTEP:0][LW-1:0] t;
    longint v;
    t = '0;
    v = UNITY;
    for (int k = ZI; k >= 0; k--) begin
      t[k] = LW'(v);
      v = (v * 64'd61870) >>> 16;
    end
    v = UNITY;
    for (int k = ZI; k <= NSTEP; k++) begin
      t[k] = LW'(v);
      v = (v * 64'd69419) >>> 16;
    end
    return t;
  endfunction

  localparam logic [NSTEP:0][LW-1:0] LUT = build_lut();

  logic signed [GW-1:0] g, gmax, att_s, dec_s, g_dn, g_up;
  logic [GW-1:0]        off;
  logic [IW-1:0]        idx, idx_hi;
  logic [7:0]           frac8;
  logic [LW-1:0]        lo, hi, lin, s1_lin;
  logic [LW+7:0]        ip;
  logic                 s1_v;
  logic [DW-1:0]        s1_x, env, leak, mag, ynext;
  logic signed [PW-1:0] prod, sh;
  logic                 over, pos_ovf, neg_ovf;

  assign gmax  = (max_sel == 2'd0) ? '0 : (max_sel == 2'd1) ? DB6 : DB12;
  assign att_s = GW'(attack_step);
  assign dec_s = GW'(decay_step);
  assign g_dn  = g - att_s;
  assign g_up  = g + dec_s;

  assign off    = g - GMIN;
  assign idx    = IW'(off >> HALF);
  assign frac8  = 8'(off >> (HALF - 8));
  assign idx_hi = (idx >= IW'(NSTEP)) ? idx : idx + IW'(1);
  assign lo     = LUT[idx];
  assign hi     = LUT[idx_hi];
  assign ip     = (LW+8)'(hi - lo) * (LW+8)'(frac8);
  assign lin    = lo + LW'(ip >> 8);

  assign prod    = PW'($signed(s1_x)) * PW'($signed({1'b0, s1_lin}));
  assign sh      = prod >>> 14;
  assign pos_ovf = !sh[PW-1] && (|sh[PW-2:DW-1]);
  assign neg_ovf =  sh[PW-1] && !(&sh[PW-2:DW-1]);
  assign ynext   = pos_ovf ? {1'b0, {(DW-1){1'b1}}} :
                   neg_ovf ? {1'b1, {(DW-1){1'b0}}} : sh[DW-1:0];
  assign mag     = ynext[DW-1] ? DW'(-ynext) : ynext;
  assign leak    = env - (env >> LEAK);
  assign over    = env > thresh;

  always_ff @(posedge clk) begin
    if (rst || !en) g <= '0;
    else if (g > gmax) g <= gmax;
    else if (in_valid) begin
      if (over) g <= (g_dn < GMIN) ? GMIN : g_dn;
      else if (g < gmax) g <= (g_up > gmax) ? gmax : g_up;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) env <= '0;
    else if (s1_v) env <= (mag > leak) ? mag : leak;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s1_x <= '0;
      s1_lin <= '0;
      out_valid <= 1'b0;
      out_sample <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_x   <= in_sample;
        s1_lin <= en ? lin : LW'(UNITY);
      end
      out_valid <= s1_v;
      if (s1_v) out_sample <= ynext;
    end
  end

  a_r2_gain_bounds: assert property (@(posedge clk) disable iff (rst)
    (g <= DB12) && (g >= GMIN));
  a_r3_limiter_cap: assert property (@(posedge clk) disable iff (rst)
    ($past(max_sel) == 2'd0) |-> (g <= 0));
  a_r5_rise_bound: assert property (@(posedge clk) disable iff (rst)
    $past(en) |-> ((g - $past(g)) <= $past(dec_s)));
  a_r4_fall_bound: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && ($past(g) <= $past(gmax))) |-> (($past(g) - g) <= $past(att_s)));
  a_r9_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);
  a_r10_bypass: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(en, 2)) |-> (out_sample == $past(in_sample, 2)));
endmodule

// File: tb/sim_avc_core.sv
module sim_avc_core;
  logic clk = 1'b0, rst = 1'b1, en = 1'b0, in_valid = 1'b0;
  logic [15:0] in_sample = '0, thresh = '0;
  logic [1:0]  max_sel = '0;
  logic [17:0] attack_step = '0, decay_step = '0;
  logic        out_valid;
  logic [15:0] out_sample;

  int errs = 0, checks = 0, ng = 0;
  int got [0:4095];
  int xs  [0:4095];
  longint GMIN = -(64'sd24 <<< 20);

  always #5 clk = ~clk;

  avc_core u0 (.clk(clk), .rst(rst), .en(en), .in_valid(in_valid), .in_sample(in_sample),
    .thresh(thresh), .max_sel(max_sel), .attack_step(attack_step), .decay_step(decay_step),
    .out_valid(out_valid), .out_sample(out_sample));

  function automatic longint lut_at(int k);
    longint v = 16384;
    if (k >= 48) for (int j = 48; j < k; j++) v = (v * 69419) >>> 16;
    else for (int j = 48; j > k; j--) v = (v * 61870) >>> 16;
    return v;
  endfunction

  function automatic int exp_y(int x, longint g);
    longint off = g + (64'sd24 <<< 20);
    int i = int'(off >>> 19);
    longint f = (off >>> 11) & 255;
    longint lo = lut_at(i);
    longint hi = (i >= 72) ? lo : lut_at(i + 1);
    longint lin = lo + (((hi - lo) * f) >>> 8);
    longint p = (longint'(x) * lin) >>> 14;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(logic v, int x);
    @(negedge clk);
    if (out_valid) begin got[ng] = int'($signed(out_sample)); ng++; end
    in_valid = v;
    in_sample = 16'(x);
  endtask

  task automatic run(int n);
    ng = 0;
    for (int k = 0; k < n; k++) step(1'b1, xs[k]);
    step(1'b0, 0);
    step(1'b0, 0);
  endtask

  task automatic flush();
    en = 1'b0;
    for (int k = 0; k < 3; k++) step(1'b0, 0);
  endtask

  initial begin
    #2_000_000;
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int n;
    longint g;
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset data", int'(out_sample), 0);
    rst = 1'b0;
    step(1'b0, 0);
    check("R1 post-reset valid", int'(out_valid), 0);

    // R10: bypass sweep over the full signed range, ceiling and threshold irrelevant
    max_sel = 2'd2; thresh = 16'd0; decay_step = 18'd200000; attack_step = 18'd200000;
    n = 0;
    for (int x = -32768; x <= 32767; x += 257) begin xs[n] = x; n++; end
    xs[n] = 32767; n++;
    run(n);
    check("R10 bypass count", ng, n);
    for (int k = 0; k < n; k++) check("R10 bypass data", got[k], xs[k]);

    // R9: single isolated sample
    step(1'b1, 1234);
    step(1'b0, 0);
    check("R9 not after one edge", int'(out_valid), 0);
    step(1'b0, 0);
    check("R9 valid after two edges", int'(out_valid), 1);
    check("R9 data", int'($signed(out_sample)), 1234);
    flush();

    // R3: limiter with threshold never exceeded
    en = 1'b1; max_sel = 2'd0; thresh = 16'hFFFF; attack_step = 18'd200000; decay_step = 18'd150001;
    n = 0;
    for (int x = -32767; x <= 32767; x += 331) begin xs[n] = x; n++; end
    run(n);
    for (int k = 0; k < n; k++) check("R3 limiter passthrough", got[k], xs[k]);
    flush();

    // R5/R7: decay ramp toward 12 dB
    en = 1'b1; max_sel = 2'd2; decay_step = 18'd150001;
    for (int k = 0; k < 100; k++) xs[k] = 1000;
    run(100);
    for (int k = 0; k < 100; k++) begin
      g = longint'(k) * 150001;
      if (g > (64'sd12 <<< 20)) g = 64'sd12 <<< 20;
      check("R5 decay ramp", got[k], exp_y(1000, g));
    end
    flush();

    // R2: 6 dB ceiling, negative input
    en = 1'b1; max_sel = 2'd1;
    for (int k = 0; k < 80; k++) xs[k] = -3000;
    run(80);
    for (int k = 0; k < 80; k++) begin
      g = longint'(k) * 150001;
      if (g > (64'sd6 <<< 20)) g = 64'sd6 <<< 20;
      check("R2 ceiling 6dB", got[k], exp_y(-3000, g));
    end
    flush();

    // R2: code 3 behaves as 12 dB
    en = 1'b1; max_sel = 2'd3;
    for (int k = 0; k < 120; k++) xs[k] = 777;
    run(120);
    check("R2 code3 ceiling", got[119], exp_y(777, 64'sd12 <<< 20));
    flush();

    // R8: saturation both directions
    en = 1'b1; max_sel = 2'd2;
    for (int k = 0; k < 120; k++) xs[k] = 20000;
    run(120);
    check("R8 saturate high", got[119], 32767);
    for (int k = 0; k < 120; k++) check("R8 ramp exact", got[k],
      exp_y(20000, (longint'(k) * 150001 > (64'sd12 <<< 20)) ? (64'sd12 <<< 20) : longint'(k) * 150001));
    flush();
    en = 1'b1;
    for (int k = 0; k < 120; k++) xs[k] = -20000;
    run(120);
    check("R8 saturate low", got[119], -32768);
    flush();

    // R4: attack down to the -24 dB floor
    en = 1'b1; max_sel = 2'd0; thresh = 16'd1000; attack_step = 18'd200000;
    for (int k = 0; k < 200; k++) xs[k] = 30000;
    run(200);
    for (int k = 0; k < 200; k++) begin
      g = (k <= 2) ? 0 : -(longint'(k - 2) * 200000);
      if (g < GMIN) g = GMIN;
      check("R4 attack ramp", got[k], exp_y(30000, g));
    end

    // R6: envelope leak and recovery
    for (int k = 0; k < 1200; k++) xs[k] = 200;
    run(1200);
    check("R6 envelope holds attenuation", got[20], exp_y(200, GMIN));
    check("R6 recovery to 0 dB", got[1199], 200);

    // R10: state reset by en low
    flush();
    en = 1'b1; thresh = 16'hFFFF;
    for (int k = 0; k < 4; k++) xs[k] = 5000;
    run(4);
    check("R10 gain reset", got[0], 5000);
    check("R1 gain starts 0 dB", got[3], 5000);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule